// File: doc/BRIEF.md
# Programmable-Tap PRBS Spreading Generator

This block produces a pseudo-random chip stream from a shift register of up to 32 stages. Which stages feed the feedback, and which stage drives the output, are both chosen at run time through a tap mask and a stage-select input. The block can be reconfigured while it runs. Each chip is combined with a serial data bit by exclusive-OR to spread it. A transmitter uses two instances, one for the in-phase path and one for the quadrature path, and gives each its own configuration.

The register advances only on a single-cycle chip-enable pulse from the chip-rate divider. The data-valid flag travels with the chip through the same register stage. The feedback is the XNOR of the selected stages, so the all-zeros reset state is a legal starting point.

There is no controller state machine. The only sequential state is the stage register and the output register, and both advance together on the chip-enable.

Top module: `prbs_spreader`

## Requirements
- R1: Reset (active-low `rst_n`) clears every stage to zero and drives `chip_out` and `chip_vld` to 0.
- R2: While `chip_en` is 0, the stages, `chip_out` and `chip_vld` hold their values, even if `tap_mask`, `stage_sel`, `data_in` or `data_vld` change.
- R3: On a `chip_en` cycle, each stage k+1 takes the old value of stage k. Stage 1 takes the XNOR of all stages whose mask bit is set, where stage k corresponds to `tap_mask` bit k-1.
- R4: A `stage_sel` value of s selects stage s+1 as the chip source. For example, a value of 31 selects stage 32.
- R5: On a `chip_en` cycle, `chip_out` becomes `data_in` XOR the selected stage, using the stage values from before that shift. The new value is visible one clock after the pulse.
- R6: On a `chip_en` cycle, `chip_vld` becomes `data_vld`, with the same one-clock delay as `chip_out`.
- R7: `tap_mask` and `stage_sel` are sampled only at a `chip_en` edge. A new value takes effect at the next pulse. A mask of zero gives a constant feedback of 1, which fills the register with ones.
- R8: With mask 32'h0000_0006 (stages 2 and 3), select value 2 and data 0, the chip stream starting from reset has period 7 and contains 3 ones per period. Mask 32'h8000_0003 with select value 31 follows the same XNOR rule over stages 32, 2 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_en | input | 1 | Single-cycle chip-rate advance pulse |
| tap_mask | input | 32 | Feedback stage mask; bit k-1 enables stage k |
| stage_sel | input | 5 | Output stage select; value s picks stage s+1 |
| data_in | input | 1 | Serial data bit to spread |
| data_vld | input | 1 | Data bit valid flag |
| chip_out | output | 1 | Spread chip |
| chip_vld | output | 1 | Valid flag aligned with chip_out |

## Verification
A wrong stage value, such as a shift slip or a feedback bit from the wrong stage, only shows at `chip_out` once that stage reaches the selected position. With a low select value the error appears on the next chip. With select value 31 it can take up to 32 chips to appear. For this reason the bench compares every chip against a model over long runs with several masks and selects. Errors in hold and valid alignment show up one clock after the event that causes them.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
    localparam int unsigned MAX_STAGES = 32;
    localparam int unsigned SEL_BITS   = $clog2(MAX_STAGES);
    typedef logic [MAX_STAGES-1:0] stage_vec_t;
    typedef logic [SEL_BITS-1:0]   stage_idx_t;
endpackage

// File: rtl/prbs_stage_reg.sv
module prbs_stage_reg #(
    parameter int unsigned N_STAGES = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  logic [N_STAGES-1:0] mask,
    output logic [N_STAGES-1:0] stages
);
    logic [N_STAGES-1:0] tapped;
    logic                fb_bit;

    genvar gi;
    generate
        for (gi = 0; gi < N_STAGES; gi++) begin : g_tap
            assign tapped[gi] = stages[gi] & mask[gi];
        end
    endgenerate

    assign fb_bit = ~(^tapped);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stages <= '0;
        end else if (adv) begin
            stages <= {stages[N_STAGES-2:0], fb_bit};
        end
    end

    p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> stages[N_STAGES-1:1] == $past(stages[N_STAGES-2:0]));

    p_feedback_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> stages[0] == ~(^($past(stages) & $past(mask))));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(stages));
endmodule

// File: rtl/prbs_stage_mux.sv
module prbs_stage_mux #(
    parameter int unsigned N_STAGES = 32,
    localparam int unsigned SEL_W   = $clog2(N_STAGES)
) (
    input  logic [N_STAGES-1:0] stages,
    input  logic [SEL_W-1:0]    sel,
    output logic                picked
);
    always_comb begin
        picked = 1'b0;
        for (int k = 0; k < N_STAGES; k++) begin
            if (sel == SEL_W'(k)) picked = stages[k];
        end
    end
endmodule

// File: rtl/prbs_spreader.sv
module prbs_spreader
    import prbs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        chip_en,
    input  logic [31:0] tap_mask,
    input  logic [4:0]  stage_sel,
    input  logic        data_in,
    input  logic        data_vld,
    output logic        chip_out,
    output logic        chip_vld
);
    stage_vec_t stage_q;
    logic       sel_chip;

    prbs_stage_reg #(.N_STAGES(MAX_STAGES)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (chip_en),
        .mask   (tap_mask),
        .stages (stage_q)
    );

    prbs_stage_mux #(.N_STAGES(MAX_STAGES)) u_mux (
        .stages (stage_q),
        .sel    (stage_sel),
        .picked (sel_chip)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chip_out <= 1'b0;
            chip_vld <= 1'b0;
        end else if (chip_en) begin
            chip_out <= data_in ^ sel_chip;
            chip_vld <= data_vld;
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> $stable(chip_out) && $stable(chip_vld));

    p_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chip_en |=> chip_vld == $past(data_vld));

    p_spread_r5: assert property (@(posedge clk) disable iff (!rst_n)
        chip_en |=> chip_out == ($past(data_in) ^ $past(sel_chip)));
endmodule

// File: tb/sim_prbs_spreader.sv
module sim_prbs_spreader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chip_en = 1'b0;
    logic [31:0] tap_mask = '0;
    logic [4:0]  stage_sel = '0;
    logic        data_in = 1'b0;
    logic        data_vld = 1'b0;
    logic        chip_out, chip_vld;

    int checks = 0;
    int errors = 0;
    logic [1:0]  exp_q[$];
    logic [31:0] mdl = '0;
    logic        en_q = 1'b0;
    logic        last_out = 1'b0, last_vld = 1'b0;
    logic        rec [0:63];
    int          rec_n = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    prbs_spreader u0 (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .tap_mask(tap_mask),
        .stage_sel(stage_sel), .data_in(data_in), .data_vld(data_vld),
        .chip_out(chip_out), .chip_vld(chip_vld)
    );

    always @(posedge clk) en_q <= chip_en & rst_n;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: compares each chip against the scoreboard, checks hold otherwise (R2)
    always @(negedge clk) begin
        if (rst_n && en_q) begin
            logic [1:0] e;
            if (exp_q.size() == 0) begin
                check(0, "R5 queue empty", 0, 1);
            end else begin
                e = exp_q.pop_front();
                check(chip_out == e[0], "R5/R3/R4 chip", chip_out, e[0]);
                check(chip_vld == e[1], "R6 valid", chip_vld, e[1]);
                if (rec_n < 64) begin rec[rec_n] = chip_out; rec_n++; end
            end
        end else if (rst_n && !en_q && chip_en == 1'b0) begin
            check(chip_out == last_out && chip_vld == last_vld, "R2 hold",
                  {chip_vld, chip_out}, {last_vld, last_out});
        end
        last_out = chip_out;
        last_vld = chip_vld;
    end

    // Driver: one chip pulse, expected value computed from the requirements
    task automatic send(input logic d, input logic v, input int gap);
        logic c;
        @(negedge clk);
        data_in  = d;
        data_vld = v;
        c = d ^ mdl[stage_sel];
        exp_q.push_back({v, c});
        mdl = {mdl[30:0], ~(^(mdl & tap_mask))};
        chip_en = 1'b1;
        @(negedge clk);
        chip_en = 1'b0;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            data_in  = ~data_in;
            data_vld = ~data_vld;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        chip_en = 1'b0;
        repeat (2) @(negedge clk);
        mdl = '0;
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        check(chip_out == 1'b0, "R1 chip_out reset", chip_out, 0);
        check(chip_vld == 1'b0, "R1 chip_vld reset", chip_vld, 0);

        // R1: stage 32 reads zero straight after reset
        tap_mask = 32'h8000_0003; stage_sel = 5'd31;
        send(1'b1, 1'b1, 1);

        // R8: 3-stage maximal sequence, period 7
        do_reset();
        tap_mask = 32'h0000_0006; stage_sel = 5'd2;
        rec_n = 0;
        for (int i = 0; i < 14; i++) send(1'b0, 1'b1, 0);
        repeat (2) @(negedge clk);
        begin
            int ones = 0;
            for (int i = 0; i < 7; i++) begin
                check(rec[i] == rec[i+7], "R8 period 7", rec[i+7], rec[i]);
                ones += int'(rec[i]);
            end
            check(ones == 3, "R8 ones per period", ones, 3);
        end

        // R3/R4/R5/R6: long run, 32-stage mask, several selects, idle gaps
        do_reset();
        tap_mask = 32'h8000_0003;
        for (int i = 0; i < 200; i++) begin
            stage_sel = 5'((i / 25) * 4 + 3);
            send(1'((i * 7) % 3 == 0), 1'(i % 5 != 0), i % 3);
        end

        // R7: config changes between pulses, including zero mask (ones fill)
        tap_mask = 32'h0000_0000; stage_sel = 5'd0;
        for (int i = 0; i < 40; i++) send(1'b0, 1'b1, 1);
        tap_mask = 32'hA5C3_0F11; stage_sel = 5'd17;
        for (int i = 0; i < 60; i++) begin
            if (i == 30) begin tap_mask = 32'h1234_5679; stage_sel = 5'd9; end
            send(1'(i % 2), 1'b1, 2);
        end

        // R2: change every input with chip_en low; monitor checks hold
        @(negedge clk);
        tap_mask = 32'hFFFF_FFFF; stage_sel = 5'd5;
        repeat (6) @(negedge clk);
        send(1'b1, 1'b0, 2);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R5 all chips seen", exp_q.size(), 0);
        done = 1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (100000) @(posedge clk);
                check(0, "watchdog", 0, 1);
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule